// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave side of a four-wire serial control port for a multichannel audio converter. A host lowers an active-low frame select, clocks in a 24-bit word MSB first and raises the select again. The word holds three bytes: a device identifier with a direction flag, a register index, and a data byte. Writes update a small register file, and reads return a register's contents on the serial output during the last byte.

The serial clock and frame select need not be related to the system clock. All three serial inputs pass through two-flop synchronisers before any edge is detected.

The block also reads a strap while reset is held. If the serial data input, serial clock and frame select are all low, the port stays inactive and the registers keep their defaults, except the master-clock enable bit, which is forced to 1. In that strap mode, the level sensed on the data-out pin chooses whether the audio port acts as clock master.

Top module: `ser_ctrl_slave`

## Requirements
- R1: Serial data is captured MSB first on rising serial-clock edges while the frame select is low. A 24-bit word is byte0 = {CHIP_ID[6:0], dir}, then byte1 = register index, then byte2 = data.
- R2: A frame with any bit count other than 24 between the select falling and rising changes no register.
- R3: A write happens only when byte0[7:1] equals CHIP_ID (default 7'h04, so the write byte is 0x08 and the read byte is 0x09) and dir = 0. A frame with any other identifier changes nothing.
- R4: A valid write updates register n when the frame select rises. Register n appears on `regFlat[8n+7:8n]`.
- R5: With dir = 1, the addressed register is driven on `spiMiso` MSB first during byte2, and the output enable is high. The output advances after each falling serial-clock edge. A read frame leaves all registers unchanged.
- R6: `spiMisoOe` is low whenever the frame select has been high for two system clocks, and it is low outside read frames.
- R7: A register index of NUM_REGS or above is ignored on write and reads back as 0x00.
- R8: When the serial data input, serial clock and frame select are all low during reset, `standaloneMode` is 1. All registers then hold their defaults (all zero by default), register MCLK_REG bit MCLK_BIT (register 0, bit 0) reads 1, and serial frames have no effect.
- R9: In standalone mode, `portMaster` equals the level of `spiMisoSense` during reset. In serial mode, `portMaster` is 0.
- R10: After reset in serial mode, every register is zero, `spiMisoOe` is 0 and `standaloneMode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap is read while it is low |
| spiLatchN | input | 1 | Active-low frame select |
| spiSclk | input | 1 | Serial bit clock |
| spiMosi | input | 1 | Serial data into the block |
| spiMisoSense | input | 1 | Level on the data-out pin, read as a strap during reset |
| spiMiso | output | 1 | Serial readback data |
| spiMisoOe | output | 1 | Output enable for the data-out pad driver |
| standaloneMode | output | 1 | Strap selected the fixed-default mode |
| portMaster | output | 1 | Audio serial port acts as clock master |
| regFlat | output | NUM_REGS*8 | All registers, register n at bits 8n+7:8n |

## Verification
The bench builds the block with NUM_REGS = 16, CHIP_ID = 7'h04 and the master-clock enable at register 0 bit 0. With these values, both the highest index (15) and the first out-of-range index (16) fit in the 8-bit index byte, so both edges of the address decode are exercised. It sends frames of 23, 24 and 25 bits, a wrong identifier, and read frames with non-zero data bytes. It also resets the block three times with different strap levels to cover both standalone roles and the return to serial mode.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [BYTE_W-1:0] wrAddr;
    logic [BYTE_W-1:0] wrData;
    logic              rdLoad;
    logic [BYTE_W-1:0] rdAddr;
    logic              rdShift;
  } strobe_t;
endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pinRaw,
  output logic [W-1:0] pinSync
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] stages;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages <= {2{RST_VAL[g]}};
      else        stages <= {stages[0], pinRaw[g]};
    end
    assign pinSync[g] = stages[1];
  end
endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
  import ser_ctrl_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter logic [6:0] CHIP_ID  = 7'h04
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    latchRaw,
  input  logic    sclkRaw,
  input  logic    dinRaw,
  input  logic    senseRaw,
  output strobe_t st,
  output logic    misoOe,
  output logic    standalone,
  output logic    master
);
  localparam int FRAME_BITS = 3 * BYTE_W;
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_HDR  = CW'(2 * BYTE_W - 1);
  localparam logic [CW-1:0] CNT_SH_LO = CW'(2 * BYTE_W + 1);
  localparam logic [CW-1:0] CNT_SH_HI = CW'(FRAME_BITS - 1);

  logic [2:0] syncd;
  logic latchS, sclkS, dinS;

  ser_pin_sync #(.W(3), .RST_VAL(3'b110)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .pinRaw({latchRaw, sclkRaw, dinRaw}),
    .pinSync(syncd)
  );
  assign latchS = syncd[2];
  assign sclkS  = syncd[1];
  assign dinS   = syncd[0];

  // strap capture while reset is held
  logic strapSa, strapSense;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strapSa    <= ~(latchRaw | sclkRaw | dinRaw);
      strapSense <= senseRaw;
    end
  end
  assign standalone = strapSa;
  assign master     = strapSa & strapSense;

  logic latchPrev, sclkPrev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchPrev <= 1'b1;
      sclkPrev  <= 1'b1;
    end else begin
      latchPrev <= latchS;
      sclkPrev  <= sclkS;
    end
  end

  logic latchFall, latchRise, sclkRise, sclkFall;
  assign latchFall = ~latchS & latchPrev;
  assign latchRise = latchS & ~latchPrev;
  assign sclkRise  = sclkS & ~sclkPrev & ~latchS;
  assign sclkFall  = ~sclkS & sclkPrev & ~latchS;

  logic [CW-1:0]         bitCnt;
  logic [FRAME_BITS-1:0] shiftQ;
  logic                  rdArm, rdActive;

  // decode of a complete frame (at frame-select rise)
  logic       wrChipOk, wrDir, wrAddrOk;
  logic [7:0] wrAddr;
  assign wrChipOk = shiftQ[FRAME_BITS-1 -: 7] == CHIP_ID;
  assign wrDir    = shiftQ[2*BYTE_W];
  assign wrAddr   = shiftQ[2*BYTE_W-1 -: BYTE_W];
  assign wrAddrOk = {1'b0, wrAddr} < 9'(NUM_REGS);

  // decode of header bytes (after 16 bits)
  logic       rdChipOk, rdDir;
  assign rdChipOk = shiftQ[2*BYTE_W-1 -: 7] == CHIP_ID;
  assign rdDir    = shiftQ[BYTE_W];

  always_comb begin
    st         = '0;
    st.wrEn    = ~strapSa & latchRise & (bitCnt == CNT_FULL) & wrChipOk & ~wrDir & wrAddrOk;
    st.wrAddr  = wrAddr;
    st.wrData  = shiftQ[BYTE_W-1:0];
    st.rdLoad  = ~strapSa & rdArm & rdChipOk & rdDir;
    st.rdAddr  = shiftQ[BYTE_W-1:0];
    st.rdShift = rdActive & sclkFall & (bitCnt >= CNT_SH_LO) & (bitCnt <= CNT_SH_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      shiftQ   <= '0;
      rdArm    <= 1'b0;
      rdActive <= 1'b0;
    end else begin
      rdArm <= 1'b0;
      if (latchFall) begin
        bitCnt   <= '0;
        rdActive <= 1'b0;
      end else if (latchRise) begin
        rdActive <= 1'b0;
      end else begin
        if (sclkRise) begin
          shiftQ <= {shiftQ[FRAME_BITS-2:0], dinS};
          if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
          rdArm <= (bitCnt == CNT_HDR);
        end
        if (st.rdLoad) rdActive <= 1'b1;
      end
    end
  end

  assign misoOe = rdActive & ~latchS;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CNT_SAT);
  p_wr_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrEn |-> $past(latchS == 1'b0));
  p_sa_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strapSa |-> !rdActive);
endmodule

// File: rtl/ser_reg_dp.sv
module ser_reg_dp
  import ser_ctrl_pkg::*;
#(
  parameter int                       NUM_REGS     = 16,
  parameter logic [NUM_REGS*8-1:0]    REG_DEFAULTS = '0,
  parameter int                       MCLK_REG     = 0,
  parameter int                       MCLK_BIT     = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  st,
  input  logic                     standalone,
  output logic                     miso,
  output logic [NUM_REGS*8-1:0]    regFlat
);
  localparam int AW = $clog2(NUM_REGS);

  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic [BYTE_W-1:0] rdSh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= REG_DEFAULTS[i*8 +: 8];
    end else if (st.wrEn) begin
      regs[st.wrAddr[AW-1:0]] <= st.wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdSh <= '0;
    end else if (st.rdLoad) begin
      rdSh <= ({1'b0, st.rdAddr} < 9'(NUM_REGS)) ? regs[st.rdAddr[AW-1:0]] : '0;
    end else if (st.rdShift) begin
      rdSh <= {rdSh[BYTE_W-2:0], 1'b0};
    end
  end
  assign miso = rdSh[BYTE_W-1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    localparam logic [7:0] FORCE = (g == MCLK_REG) ? 8'(1 << MCLK_BIT) : 8'h00;
    assign regFlat[g*8 +: 8] = standalone ? (REG_DEFAULTS[g*8 +: 8] | FORCE) : regs[g];
  end

  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrEn |=> regs[$past(st.wrAddr[AW-1:0])] == $past(st.wrData));
  p_sa_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standalone |-> !st.wrEn && !st.rdLoad);
endmodule

// File: rtl/ser_ctrl_slave.sv
module ser_ctrl_slave
  import ser_ctrl_pkg::*;
#(
  parameter int                    NUM_REGS     = 16,
  parameter logic [6:0]            CHIP_ID      = 7'h04,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = '0,
  parameter int                    MCLK_REG     = 0,
  parameter int                    MCLK_BIT     = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spiLatchN,
  input  logic                  spiSclk,
  input  logic                  spiMosi,
  input  logic                  spiMisoSense,
  output logic                  spiMiso,
  output logic                  spiMisoOe,
  output logic                  standaloneMode,
  output logic                  portMaster,
  output logic [NUM_REGS*8-1:0] regFlat
);
  strobe_t st;

  ser_frame_ctrl #(.NUM_REGS(NUM_REGS), .CHIP_ID(CHIP_ID)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .latchRaw(spiLatchN), .sclkRaw(spiSclk), .dinRaw(spiMosi), .senseRaw(spiMisoSense),
    .st(st), .misoOe(spiMisoOe), .standalone(standaloneMode), .master(portMaster)
  );

  ser_reg_dp #(.NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS),
               .MCLK_REG(MCLK_REG), .MCLK_BIT(MCLK_BIT)) i_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .standalone(standaloneMode),
    .miso(spiMiso), .regFlat(regFlat)
  );

  p_oe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spiLatchN, 2) && $past(spiLatchN)) |-> !spiMisoOe);
endmodule

// File: tb/test_ser_ctrl_slave.sv
module test_ser_ctrl_slave;
  localparam int NREG = 16;
  localparam int H = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic latchN = 1, sclk = 1, mosi = 1, sense = 0;
  logic miso, misoOe, saMode, pMaster;
  logic [NREG*8-1:0] regFlat;
  logic [NREG*8-1:0] model;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_ctrl_slave i_ser_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .spiLatchN(latchN), .spiSclk(sclk), .spiMosi(mosi),
    .spiMisoSense(sense), .spiMiso(miso), .spiMisoOe(misoOe),
    .standaloneMode(saMode), .portMaster(pMaster), .regFlat(regFlat)
  );

  // {frame, bit count, readback index, expected byte}
  localparam logic [47:0] VEC [9] = '{
    {24'h0803A5, 8'd24, 8'h03, 8'hA5},
    {24'h08073C, 8'd24, 8'h07, 8'h3C},
    {24'h0A03FF, 8'd24, 8'h03, 8'hA5},
    {24'h080700, 8'd23, 8'h07, 8'h3C},
    {24'h080700, 8'd25, 8'h07, 8'h3C},
    {24'h080F81, 8'd24, 8'h0F, 8'h81},
    {24'h08005A, 8'd24, 8'h00, 8'h5A},
    {24'h081077, 8'd24, 8'h10, 8'h00},
    {24'h0903FF, 8'd24, 8'h03, 8'hA5}
  };

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic l, input logic c, input logic d, input logic s);
    @(negedge clk);
    rst_n = 0; latchN = l; sclk = c; mosi = d; sense = s;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [23:0] f, input int len,
                           output logic [7:0] rd, output logic oeSeen);
    rd = '0; oeSeen = 0;
    latchN = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      sclk = 0;
      mosi = (i < 24) ? f[23-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i >= 16 && i < 24) begin
        rd[23-i] = miso;
        oeSeen |= misoOe;
      end
      sclk = 1;
      repeat (H) @(negedge clk);
    end
    latchN = 1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    model = '0;
    doReset(1, 1, 1, 0);
    // R10 reset state
    chk(regFlat == '0, "R10 regs", regFlat, 0);
    chk(misoOe == 0, "R10 oe", misoOe, 0);
    chk(saMode == 0, "R10 standalone", saMode, 0);
    chk(pMaster == 0, "R9 serial-mode role", pMaster, 0);

    foreach (VEC[k]) begin
      logic [23:0] f;
      int len;
      logic [7:0] ra, ex;
      f = VEC[k][47:24]; len = int'(VEC[k][23:16]); ra = VEC[k][15:8]; ex = VEC[k][7:0];
      sendFrame(f, len, rd, oe);
      // expected register image from R1..R4, R7
      if (len == 24 && f[23:17] == 7'h04 && !f[16] && f[15:8] < 8'(NREG))
        model[f[15:8]*8 +: 8] = f[7:0];
      chk(regFlat == model, "R1 R2 R3 R4 R7 register image", regFlat, model);
      chk(misoOe == 0, "R6 oe after frame", misoOe, 0);
      sendFrame({8'h09, ra, 8'hC3}, 24, rd, oe);
      chk(rd == ex, "R5 R7 readback", rd, ex);
      chk(oe == 1, "R5 oe during read", oe, 1);
      chk(regFlat == model, "R5 read leaves regs", regFlat, model);
    end

    // R8/R9 standalone, master role
    doReset(0, 0, 0, 1);
    chk(saMode == 1, "R8 standalone", saMode, 1);
    chk(pMaster == 1, "R9 master", pMaster, 1);
    chk(regFlat == 128'h1, "R8 defaults", regFlat, 128'h1);
    latchN = 1; sclk = 1;
    repeat (5) @(negedge clk);
    sendFrame(24'h0803EE, 24, rd, oe);
    chk(regFlat == 128'h1, "R8 frames ignored", regFlat, 128'h1);
    sendFrame(24'h090000, 24, rd, oe);
    chk(oe == 0, "R8 no readback drive", oe, 0);

    doReset(0, 0, 0, 0);
    chk(saMode == 1 && pMaster == 0, "R9 slave role", {saMode, pMaster}, 2'b10);

    doReset(0, 1, 0, 1);
    chk(saMode == 0 && pMaster == 0, "R8 R9 serial again", {saMode, pMaster}, 2'b00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule